// File: doc/BRIEF.md
# Eight-Channel Converter Channel Sequencer

This block is the channel selection logic placed in front of a multi-input converter. A parallel write port loads a control word. A second register, the channel mask, is loaded by the write that follows a particular control code. On each conversion-start pulse the block decides which input the multiplexer presents next. It drives that address on `mux_addr` and latches the address of the channel just sampled on `result_tag`, so that a result can be matched to its channel after the sequencer has moved on.

A small state machine gives the meaning of every write. In `ST_SINGLE` each control write names one channel. A control write with the load-mask code moves the machine to `ST_MASKWAIT`, and there the next write is taken as the mask. The mask write moves it to `ST_RING`. In `ST_RING` every conversion start steps upward through the channels enabled in the mask and wraps from the highest back to the lowest. A control write with the keep-ring code leaves the machine in its state. The select codes (00 and 11) return it to `ST_SINGLE`. The load-mask code (01) sends it to `ST_MASKWAIT` from either of the other states.

Control word layout on `wr_data`: bit 0 is the load-mask flag, bit 1 is the ring flag, and bits 4..2 hold a channel number. A mask write uses bits 7..0, and bit n enables channel n. All strobes are single-cycle pulses that are sampled on the rising clock edge.

Top module: `chan_sequencer`

## Requirements
- R1: After reset, `mux_addr` and `result_tag` are 0, the mask is empty and the machine is in `ST_SINGLE`.
- R2: A control write with ring=0 and load-mask=0 made outside `ST_MASKWAIT` sets `mux_addr` to bits 4..2 of that write in the following cycle and enters `ST_SINGLE`.
- R3: A control write with ring=0 and load-mask=1 leaves `mux_addr` unchanged and makes the next write a mask write.
- R4: A mask write stores bits 7..0 as the mask, enters `ST_RING` and sets `mux_addr` to the lowest enabled channel. If the written mask is zero, `mux_addr` keeps its value.
- R5: In `ST_RING`, each conversion start moves `mux_addr` to the next higher enabled channel, wrapping from the highest enabled channel to the lowest. A single enabled channel repeats.
- R6: In `ST_RING`, a control write with ring=1 and load-mask=0 keeps the sequence running and the address unchanged. Its channel field is ignored.
- R7: A control write with ring=1 and load-mask=1 ends a sequence and behaves as a single-channel select of bits 4..2.
- R8: In `ST_RING` with an empty mask, conversion starts leave `mux_addr` unchanged.
- R9: On each conversion start, `result_tag` takes the value `mux_addr` had in that cycle and holds it until the next conversion start.
- R10: When a write and a conversion start arrive in the same cycle, the write decides the next `mux_addr`, while `result_tag` still takes the address before the write.
- R11: In `ST_SINGLE`, a control write with ring=1 and load-mask=0 has no effect on the address or the mode.
- R12: Conversion starts in `ST_SINGLE` or `ST_MASKWAIT` leave `mux_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 12 | Write data: control word or mask |
| conv_start | input | 1 | Single-cycle conversion-start pulse |
| mux_addr | output | 3 | Channel presented to the input multiplexer |
| result_tag | output | 3 | Channel of the most recent conversion |

## Verification
A wrong mode state shows up at the first conversion start after it occurs. The address then moves when it should hold, or holds when it should step, and the error appears on `mux_addr` one cycle after the pulse. A corrupted mask or a wrong wrap search produces an address outside the enabled set within one full pass of the ring. Any error in the address reaches `result_tag` one conversion later, so a tag fault can be told apart from an address fault by the cycle in which the mismatch appears.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
    typedef enum logic [1:0] {
        ST_SINGLE   = 2'd0,
        ST_MASKWAIT = 2'd1,
        ST_RING     = 2'd2
    } mode_e;

    localparam int BIT_LOAD = 0;
    localparam int BIT_RING = 1;
    localparam int ADDR_LSB = 2;
endpackage

// File: rtl/chseq_mode_fsm.sv
module chseq_mode_fsm
    import chseq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    output mode_e          mode,
    output logic [NCH-1:0] mask,
    output logic           sel_wr,
    output logic           mask_wr
);
    mode_e mode_d;
    logic  f_ring, f_load;

    assign f_ring = wr_data[BIT_RING];
    assign f_load = wr_data[BIT_LOAD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= ST_SINGLE;
        else        mode <= mode_d;
    end

    always_comb begin
        mode_d = mode;
        unique case (mode)
            ST_SINGLE, ST_RING: begin
                if (wr_en) begin
                    unique case ({f_ring, f_load})
                        2'b00, 2'b11: mode_d = ST_SINGLE;
                        2'b01:        mode_d = ST_MASKWAIT;
                        2'b10:        mode_d = mode;
                    endcase
                end
            end
            ST_MASKWAIT: if (wr_en) mode_d = ST_RING;
            default:     mode_d = ST_SINGLE;
        endcase
    end

    always_comb begin
        sel_wr  = 1'b0;
        mask_wr = 1'b0;
        unique case (mode)
            ST_SINGLE, ST_RING: sel_wr = wr_en && (f_ring == f_load);
            ST_MASKWAIT:        mask_wr = wr_en;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= wr_data[NCH-1:0];
    end

    a_r4_enter_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_MASKWAIT && wr_en) |=> (mode == ST_RING));
    a_r7_leave_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_RING && wr_en && f_ring && f_load) |=> (mode == ST_SINGLE));
    a_r11_keep_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_SINGLE && wr_en && f_ring && !f_load) |=> (mode == ST_SINGLE));
endmodule

// File: rtl/chseq_scan.sv
module chseq_scan #(
    parameter int NCH = 8,
    localparam int AW = $clog2(NCH)
) (
    input  logic [NCH-1:0] seq_mask,
    input  logic [AW-1:0]  cur,
    input  logic [NCH-1:0] cand_mask,
    output logic [AW-1:0]  next_up,
    output logic [AW-1:0]  first_set,
    output logic           cand_any
);
    always_comb begin
        next_up = cur;
        for (int k = NCH; k >= 1; k--) begin
            int j;
            j = (int'(cur) + k) % NCH;
            if (seq_mask[j]) next_up = AW'(j);
        end
    end

    always_comb begin
        first_set = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand_mask[i]) first_set = AW'(i);
        end
    end

    assign cand_any = |cand_mask;
endmodule

// File: rtl/chseq_tag.sv
module chseq_tag #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] tag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tag <= '0;
        else if (conv) tag <= addr;
    end

    a_r9_tag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        conv |=> (tag == $past(addr)));
    a_r9_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conv |=> $stable(tag));
endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer
    import chseq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 12,
    localparam int AW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          conv_start,
    output logic [AW-1:0] mux_addr,
    output logic [AW-1:0] result_tag
);
    mode_e          mode;
    logic [NCH-1:0] mask;
    logic           sel_wr, mask_wr;
    logic [AW-1:0]  next_up, first_set;
    logic           cand_any;

    chseq_mode_fsm #(.NCH(NCH), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode(mode), .mask(mask), .sel_wr(sel_wr), .mask_wr(mask_wr)
    );

    chseq_scan #(.NCH(NCH)) u_scan (
        .seq_mask(mask), .cur(mux_addr), .cand_mask(wr_data[NCH-1:0]),
        .next_up(next_up), .first_set(first_set), .cand_any(cand_any)
    );

    chseq_tag #(.AW(AW)) u_tag (
        .clk(clk), .rst_n(rst_n), .conv(conv_start),
        .addr(mux_addr), .tag(result_tag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mux_addr <= '0;
        else if (sel_wr)
            mux_addr <= wr_data[ADDR_LSB +: AW];
        else if (mask_wr && cand_any)
            mux_addr <= first_set;
        else if (conv_start && mode == ST_RING && !wr_en)
            mux_addr <= next_up;
    end

    a_r2_select: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode != ST_MASKWAIT && !wr_data[BIT_RING] && !wr_data[BIT_LOAD])
        |=> (mux_addr == $past(wr_data[ADDR_LSB +: AW])));
    a_r5_lands_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_RING && conv_start && !wr_en && mask != '0) |=> mask[mux_addr]);
    a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_RING && mask == '0 && !wr_en) |=> $stable(mux_addr));
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && conv_start) |=> (mux_addr == $past(wr_data[ADDR_LSB +: AW])));
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (!conv_start || mode != ST_RING)) |=> $stable(mux_addr));
endmodule

// File: tb/sim_chan_sequencer.sv
module sim_chan_sequencer;
    localparam int NCH = 8;
    localparam int DW  = 12;
    localparam int AW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          conv_start = 1'b0;
    logic [AW-1:0] mux_addr, result_tag;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state: 0 single, 1 mask wait, 2 ring
    int             m_state = 0;
    logic [NCH-1:0] m_mask = '0;
    logic [AW-1:0]  m_addr = '0;
    logic [AW-1:0]  m_tag = '0;

    always #5 clk = ~clk;

    chan_sequencer #(.NCH(NCH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .conv_start(conv_start), .mux_addr(mux_addr), .result_tag(result_tag)
    );

    function automatic logic [AW-1:0] next_ch(logic [NCH-1:0] m, logic [AW-1:0] c);
        logic [AW-1:0] r = c;
        for (int k = NCH; k >= 1; k--) begin
            if (m[(int'(c) + k) % NCH]) r = AW'((int'(c) + k) % NCH);
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] ctl(bit ring, bit load, int ch);
        logic [DW-1:0] d = '0;
        d[0] = load;
        d[1] = ring;
        d[4:2] = 3'(ch);
        return d;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(bit w, logic [DW-1:0] d, bit c, string req);
        @(negedge clk);
        wr_en = w;
        wr_data = d;
        conv_start = c;
        if (c) m_tag = m_addr;
        if (w) begin
            if (m_state == 1) begin
                m_mask = d[NCH-1:0];
                if (m_mask != 0) begin
                    for (int i = NCH - 1; i >= 0; i--) if (m_mask[i]) m_addr = AW'(i);
                end
                m_state = 2;
            end else if (d[1] == d[0]) begin
                m_addr = d[4:2];
                m_state = 0;
            end else if (d[0]) begin
                m_state = 1;
            end
        end else if (c && m_state == 2) begin
            m_addr = next_ch(m_mask, m_addr);
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        conv_start = 1'b0;
        check(req, "mux_addr", int'(mux_addr), int'(m_addr));
        check("R9", "result_tag", int'(result_tag), int'(m_tag));
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "mux_addr", int'(mux_addr), 0);
        check("R1", "result_tag", int'(result_tag), 0);
        @(negedge clk);
        rst_n = 1'b1;

        step(1, ctl(0, 0, 5), 0, "R2");
        step(0, '0, 1, "R12");
        step(1, ctl(1, 0, 3), 0, "R11");
        step(0, '0, 1, "R11");
        step(1, ctl(0, 1, 6), 0, "R3");
        step(0, '0, 1, "R12");
        step(1, 12'h0A4, 0, "R4");
        step(0, '0, 1, "R5");
        step(0, '0, 1, "R5");
        step(0, '0, 1, "R5");
        step(1, ctl(1, 0, 1), 0, "R6");
        step(0, '0, 1, "R6");
        step(1, ctl(1, 0, 7), 1, "R10");
        step(1, ctl(0, 0, 4), 1, "R10");
        step(0, '0, 1, "R12");
        step(1, ctl(0, 1, 0), 0, "R3");
        step(1, 12'h000, 0, "R4");
        step(0, '0, 1, "R8");
        step(0, '0, 1, "R8");
        step(1, ctl(0, 1, 0), 0, "R3");
        step(1, 12'h040, 0, "R4");
        step(0, '0, 1, "R5");
        step(1, ctl(1, 1, 2), 0, "R7");
        step(0, '0, 1, "R7");

        seed = $urandom(32'd20240611);
        for (int n = 0; n < 3000; n++) begin
            int unsigned r = $urandom();
            int unsigned p = r % 16;
            bit c = r[8];
            if (m_state == 1 || p < 2)
                step(1, DW'($urandom()), c, "R4");
            else if (p < 4)
                step(1, ctl(r[9], r[9], int'(r[12:10])), c, "R2");
            else if (p == 4)
                step(1, ctl(0, 1, int'(r[12:10])), c, "R3");
            else if (p < 7)
                step(1, ctl(1, 0, int'(r[12:10])), c, "R6");
            else
                step(0, '0, c, "R5");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule